// File: doc/BRIEF.md
# Processor Mode and Privilege Controller

This block keeps the mode field of a processor status word and rules on every request to change it. Two kinds of request reach it: a software mode write that names a target mode, and an exception entry that names an exception kind. Each exception kind goes to its own privileged mode. A software write is checked against the current privilege level and the rules on the user and system modes. A rejected write leaves the mode as it was and raises an illegal flag for one cycle.

The block drives the current mode and the privilege level it implies (PL0 for user mode, PL1 for the rest). On each exception entry it also sends a one-cycle save strobe and the target mode to the banked register file. In the same cycle that the mode changes, the register file copies the old status word into the saved status register of that mode. Vector generation, the register storage and memory protection are handled by other blocks.

Top module: `pmc_top`

## Requirements
- R1: After reset `mode` is supervisor (5'h13), `priv` is 1, and `illegal` and `save_stb` are 0.
- R2: `priv` is 0 exactly when `mode` is user (5'h10) and 1 in every other mode.
- R3: A software request (`sw_req`) made in user mode leaves the mode unchanged and sets `illegal` one cycle later. The only way out of user mode is an exception.
- R4: A software request in a privileged mode to any assigned mode moves `mode` there one cycle later, with `illegal` and `save_stb` both 0. The assigned modes are user 5'h10, fast interrupt 5'h11, normal interrupt 5'h12, supervisor 5'h13, abort 5'h17, undefined 5'h1B and system 5'h1F.
- R5: A software request from system mode to user mode is rejected: `illegal` is 1 and the mode does not change.
- R6: A software request that targets an unassigned 5-bit value is rejected: `illegal` is 1 and the mode does not change.
- R7: An exception (`exc_req`) enters the mode its kind maps to, one cycle later and from any mode, user mode included. The kinds on `exc_kind` map as follows: 0 fast interrupt → 5'h11, 1 normal interrupt → 5'h12, 2 prefetch abort → 5'h17, 3 data abort → 5'h17, 4 undefined instruction → 5'h1B, 5 supervisor call → 5'h13. No exception ever enters user or system mode.
- R8: In the same cycle that an exception changes the mode, `save_stb` is 1 for one cycle and `save_mode` equals the new mode. Software changes never raise `save_stb`.
- R9: When an exception and a software request arrive in the same cycle, the exception is taken, the software request is dropped, and `illegal` stays 0.
- R10: An exception with a reserved kind (6 or 7) is rejected: `illegal` is 1, `save_stb` is 0 and the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_req | input | 1 | Software mode-change request, held for one cycle |
| sw_mode | input | 5 | Target mode of the software request |
| exc_req | input | 1 | Exception-entry request, held for one cycle |
| exc_kind | input | KIND_W (3) | Exception kind |
| mode | output | 5 | Current mode |
| priv | output | 1 | Privilege level: 0 = PL0, 1 = PL1 |
| illegal | output | 1 | Pulses for one cycle after a rejected request |
| save_stb | output | 1 | Tells the register file to save the old status word |
| save_mode | output | 5 | Mode whose saved status register takes the copy |

## Verification
Every result is registered. A request that is sampled at a rising edge shows its effect on `mode`, `priv`, `illegal`, `save_stb` and `save_mode` just after that edge, so the results are due one cycle after the request. All outputs go back to their idle meaning at the next edge. The bench drives each request on a falling edge and lets one rising edge pass. It checks on the next falling edge, which keeps every check away from the edge. It then checks again one cycle later to confirm that the `illegal` and `save_stb` pulses last a single cycle and that a rejected request left the mode alone.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int MODE_W   = 5;
   localparam int N_MODES  = 7;

   localparam logic [MODE_W-1:0] M_USER = 5'h10;
   localparam logic [MODE_W-1:0] M_FAST = 5'h11;
   localparam logic [MODE_W-1:0] M_NORM = 5'h12;
   localparam logic [MODE_W-1:0] M_SUPV = 5'h13;
   localparam logic [MODE_W-1:0] M_ABRT = 5'h17;
   localparam logic [MODE_W-1:0] M_UNDF = 5'h1B;
   localparam logic [MODE_W-1:0] M_SYST = 5'h1F;

   localparam logic [MODE_W-1:0] MODE_TABLE [N_MODES] =
      '{M_USER, M_FAST, M_NORM, M_SUPV, M_ABRT, M_UNDF, M_SYST};

   typedef enum logic [2:0] {
      K_FAST  = 3'd0,
      K_NORM  = 3'd1,
      K_PABT  = 3'd2,
      K_DABT  = 3'd3,
      K_UNDEF = 3'd4,
      K_SCALL = 3'd5
   } exc_kind_e;

   localparam int N_KINDS = 6;

   typedef struct packed {
      logic                 upd;
      logic [MODE_W-1:0]    nxt;
      logic                 bad;
      logic                 save;
   } pmc_decision_t;
endpackage

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
   import pmc_pkg::*;
(
   input  logic [MODE_W-1:0] code,
   output logic              assigned,
   output logic              is_user,
   output logic              is_system
);
   logic [N_MODES-1:0] hit;

   for (genvar g = 0; g < N_MODES; g++) begin : g_match
      assign hit[g] = (code == MODE_TABLE[g]);
   end

   assign assigned  = |hit;
   assign is_user   = (code == M_USER);
   assign is_system = (code == M_SYST);
endmodule

// File: rtl/pmc_exc_map.sv
module pmc_exc_map
   import pmc_pkg::*;
#(
   parameter int KIND_W = 3
)(
   input  logic [KIND_W-1:0] kind,
   output logic [MODE_W-1:0] target,
   output logic              known
);
   localparam int N_CODES = 1 << KIND_W;

   if (KIND_W < 3) begin : g_bad_width
      initial $error("pmc_exc_map: KIND_W must be at least 3");
   end

   always_comb begin
      target = M_SUPV;
      known  = 1'b1;
      if (int'(kind) >= N_KINDS) begin
         known = 1'b0;
      end else begin
         case (exc_kind_e'(kind[2:0]))
            K_FAST:  target = M_FAST;
            K_NORM:  target = M_NORM;
            K_PABT:  target = M_ABRT;
            K_DABT:  target = M_ABRT;
            K_UNDEF: target = M_UNDF;
            K_SCALL: target = M_SUPV;
            default: known  = 1'b0;
         endcase
      end
   end

   initial begin
      if (N_CODES < N_KINDS) $error("pmc_exc_map: kind field too narrow");
   end
endmodule

// File: rtl/pmc_arbiter.sv
module pmc_arbiter
   import pmc_pkg::*;
(
   input  logic              cur_user,
   input  logic              cur_system,
   input  logic              sw_req,
   input  logic [MODE_W-1:0] sw_target,
   input  logic              sw_assigned,
   input  logic              sw_to_user,
   input  logic              exc_req,
   input  logic [MODE_W-1:0] exc_target,
   input  logic              exc_known,
   output pmc_decision_t     dec
);
   always_comb begin
      dec = '{upd: 1'b0, nxt: exc_target, bad: 1'b0, save: 1'b0};
      if (exc_req) begin
         // exceptions outrank software writes
         if (exc_known) begin
            dec.upd  = 1'b1;
            dec.nxt  = exc_target;
            dec.save = 1'b1;
         end else begin
            dec.bad  = 1'b1;
         end
      end else if (sw_req) begin
         if (cur_user || !sw_assigned || (cur_system && sw_to_user)) begin
            dec.bad = 1'b1;
         end else begin
            dec.upd = 1'b1;
            dec.nxt = sw_target;
         end
      end
   end
endmodule

// File: rtl/pmc_top.sv
module pmc_top
   import pmc_pkg::*;
#(
   parameter int                KIND_W     = 3,
   parameter logic [MODE_W-1:0] RESET_MODE = M_SUPV
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_req,
   input  logic [MODE_W-1:0] sw_mode,
   input  logic              exc_req,
   input  logic [KIND_W-1:0] exc_kind,
   output logic [MODE_W-1:0] mode,
   output logic              priv,
   output logic              illegal,
   output logic              save_stb,
   output logic [MODE_W-1:0] save_mode
);
   localparam logic RESET_PRIV = (RESET_MODE != M_USER);

   initial begin
      if (RESET_MODE != M_SUPV && RESET_MODE != M_SYST && RESET_MODE != M_USER &&
          RESET_MODE != M_FAST && RESET_MODE != M_NORM && RESET_MODE != M_ABRT &&
          RESET_MODE != M_UNDF)
         $error("pmc_top: RESET_MODE is not an assigned mode");
   end

   logic              cur_user, cur_system, cur_assigned;
   logic              sw_assigned, sw_to_user, sw_to_system;
   logic [MODE_W-1:0] exc_target;
   logic              exc_known;
   pmc_decision_t     dec;

   pmc_mode_decode u_cur_dec (
      .code(mode), .assigned(cur_assigned),
      .is_user(cur_user), .is_system(cur_system));

   pmc_mode_decode u_sw_dec (
      .code(sw_mode), .assigned(sw_assigned),
      .is_user(sw_to_user), .is_system(sw_to_system));

   pmc_exc_map #(.KIND_W(KIND_W)) u_map (
      .kind(exc_kind), .target(exc_target), .known(exc_known));

   pmc_arbiter u_arb (
      .cur_user(cur_user), .cur_system(cur_system),
      .sw_req(sw_req), .sw_target(sw_mode), .sw_assigned(sw_assigned),
      .sw_to_user(sw_to_user), .exc_req(exc_req),
      .exc_target(exc_target), .exc_known(exc_known), .dec(dec));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= RESET_MODE;
         priv      <= RESET_PRIV;
         illegal   <= 1'b0;
         save_stb  <= 1'b0;
         save_mode <= RESET_MODE;
      end else begin
         illegal  <= dec.bad;
         save_stb <= dec.save;
         if (dec.upd) begin
            mode <= dec.nxt;
            priv <= (dec.nxt != M_USER);
         end
         if (dec.save) save_mode <= dec.nxt;
      end
   end

   // R2: privilege register tracks the mode register
   assert_priv_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      priv == (mode != M_USER));

   // R3: user-mode software requests are refused
   assert_user_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_user && sw_req && !exc_req) |=> (illegal && mode == M_USER));

   // R5: system to user is refused
   assert_sys_to_user_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_system && sw_req && !exc_req && sw_mode == M_USER) |=> (illegal && $stable(mode)));

   // R7: exceptions never land in user or system mode
   assert_exc_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      save_stb |-> (mode != M_USER && mode != M_SYST));

   // R8: strobe names the mode just entered
   assert_save_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      save_stb |-> (save_mode == mode));

   // R9: exception wins over software request
   assert_exc_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && exc_known) |=> (save_stb && !illegal));

   // R6: mode register only ever holds assigned values
   assert_mode_assigned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cur_assigned);
endmodule

// File: tb/test_pmc_top.sv
`timescale 1ns/1ps
module test_pmc_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_req = 1'b0;
   logic [4:0] sw_mode = 5'h0;
   logic       exc_req = 1'b0;
   logic [2:0] exc_kind = 3'd0;
   logic [4:0] mode, save_mode;
   logic       priv, illegal, save_stb;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pmc_top i_pmc_top (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_mode(sw_mode),
      .exc_req(exc_req), .exc_kind(exc_kind), .mode(mode), .priv(priv),
      .illegal(illegal), .save_stb(save_stb), .save_mode(save_mode));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive for one rising edge, then return at the next falling edge
   task automatic step(bit s, logic [4:0] sm, bit e, logic [2:0] k);
      sw_req = s; sw_mode = sm; exc_req = e; exc_kind = k;
      @(posedge clk);
      @(negedge clk);
      sw_req = 1'b0; exc_req = 1'b0;
   endtask

   task automatic sw_go(logic [4:0] m);
      step(1, m, 0, 3'd0);
   endtask

   task automatic t_reset;
      check("R1 mode", mode, 5'h13);
      check("R1 priv", priv, 1);
      check("R1 illegal", illegal, 0);
      check("R1 save_stb", save_stb, 0);
   endtask

   task automatic t_privileged_switch;
      logic [4:0] lst [6] = '{5'h11, 5'h12, 5'h17, 5'h1B, 5'h1F, 5'h13};
      foreach (lst[i]) begin
         sw_go(lst[i]);
         check("R4 mode", mode, lst[i]);
         check("R4 illegal", illegal, 0);
         check("R8 no save on software", save_stb, 0);
         check("R2 priv", priv, 1);
      end
      sw_go(5'h10);
      check("R4 to user", mode, 5'h10);
      check("R2 priv user", priv, 0);
   endtask

   task automatic t_user_locked;
      sw_go(5'h13);
      check("R3 illegal", illegal, 1);
      check("R3 mode", mode, 5'h10);
      step(0, 5'h0, 0, 3'd0);
      check("R3 pulse ends", illegal, 0);
      check("R3 still user", mode, 5'h10);
   endtask

   task automatic t_exceptions;
      logic [4:0] want [6] = '{5'h11, 5'h12, 5'h17, 5'h17, 5'h1B, 5'h13};
      for (int k = 0; k < 6; k++) begin
         step(0, 5'h0, 1, 3'(k));
         check("R7 target", mode, want[k]);
         check("R8 save_stb", save_stb, 1);
         check("R8 save_mode", save_mode, want[k]);
         check("R2 priv", priv, 1);
         step(0, 5'h0, 0, 3'd0);
         check("R8 strobe one cycle", save_stb, 0);
         sw_go(5'h10);
      end
      check("R7 back in user", mode, 5'h10);
   endtask

   task automatic t_sys_to_user;
      step(0, 5'h0, 1, 3'd5);
      sw_go(5'h1F);
      check("R4 into system", mode, 5'h1F);
      sw_go(5'h10);
      check("R5 illegal", illegal, 1);
      check("R5 mode", mode, 5'h1F);
      sw_go(5'h13);
      check("R5 system to supervisor ok", mode, 5'h13);
      check("R5 illegal cleared", illegal, 0);
   endtask

   task automatic t_unassigned;
      logic [4:0] bad [4] = '{5'h00, 5'h14, 5'h1A, 5'h0F};
      foreach (bad[i]) begin
         sw_go(bad[i]);
         check("R6 illegal", illegal, 1);
         check("R6 mode", mode, 5'h13);
      end
   endtask

   task automatic t_collision;
      step(1, 5'h1F, 1, 3'd1);
      check("R9 exception taken", mode, 5'h12);
      check("R9 no illegal", illegal, 0);
      check("R9 save", save_stb, 1);
      sw_go(5'h10);
      step(1, 5'h13, 1, 3'd4);
      check("R9 from user", mode, 5'h1B);
      check("R9 no illegal user", illegal, 0);
   endtask

   task automatic t_reserved_kind;
      step(0, 5'h0, 1, 3'd6);
      check("R10 illegal", illegal, 1);
      check("R10 no save", save_stb, 0);
      check("R10 mode", mode, 5'h1B);
      step(0, 5'h0, 1, 3'd7);
      check("R10 kind 7", mode, 5'h1B);
      check("R10 kind 7 illegal", illegal, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", mode, 5'h13);
      t_privileged_switch;
      t_user_locked;
      t_exceptions;
      t_sys_to_user;
      t_unassigned;
      t_collision;
      t_reserved_kind;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule